// File: doc/BRIEF.md
# Eight-Bit Parallel-to-Serial Converter

The block turns a parallel word into a serial NRZ bit stream, least significant bit first. Alongside the data it drives a word clock whose rising edge marks the first bit of every word. A rate input picks one of two modes. In full-rate mode one bit is sent per input clock period. In double-rate mode two bits are sent per period, one on each clock phase.

Everything runs from a single clock `clk`. One input clock period is two consecutive `clk` ticks: a rising-phase tick followed by a falling-phase tick. After `sync_rst` is released, the first tick is always a rising-phase tick. Double-rate mode is therefore an internal enable that fires on every tick, while full-rate mode fires only on rising-phase ticks.

An asynchronous synchronising reset clears the sequencer and the output stage. A synchronous clock enable freezes all internal state while it is low. A holding register takes a fresh word from `par_in` at each word boundary, so the inputs may change while a word is being shifted out.

Top module: `par2ser_top`

## Requirements
- R1: Bit i of a word (bit 0 first, through bit WORD_W-1 last) appears on `ser_out` as the i-th serial bit of that word.
- R2: `word_clk` is high while bits 0 to WORD_W/2-1 are on `ser_out` and low for the remaining bits. It rises on the tick that presents bit 0.
- R3: With `rate_full` = 1, `ser_out` advances once per two ticks, on rising-phase ticks only. `ser_out` and `word_clk` hold across each falling-phase tick.
- R4: With `rate_full` = 0, `ser_out` advances to the next bit on every tick.
- R5: While `sync_rst` = 1, `ser_out` and `word_clk` are 0 at once, without waiting for a clock edge. Raising `sync_rst` at any time clears the whole sequence.
- R6: After `sync_rst` falls, the first tick (rising phase) does nothing and the second tick (falling phase) arms the converter. The third tick (rising phase) presents bit 0 of the word on `par_in` and raises `word_clk`. Before that tick both outputs stay 0.
- R7: A tick with `clk_en` = 0 changes no state, including the clock phase. The outputs hold, and conversion resumes with the next bit once `clk_en` returns to 1.
- R8: `par_in` is sampled only on the tick that presents bit 0 of a word. Changes to it at any other time do not affect the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; two ticks form one input clock period |
| sync_rst | input | 1 | Asynchronous synchronising reset, active high |
| clk_en | input | 1 | Synchronous enable; low freezes all state |
| rate_full | input | 1 | 1: one bit per period; 0: two bits per period |
| par_in | input | WORD_W | Parallel word, sampled at each word boundary |
| ser_out | output | 1 | Serial NRZ data, LSB first |
| word_clk | output | 1 | Word-rate clock, high for the first half of each word |

## Verification
The hardest situation to reach is a freeze that lands between the two phases of a full-rate bit period. If the phase were not frozen with the rest of the state, the bit after the freeze would come one tick early. The bench drops `clk_en` for several ticks right after a rising-phase bit update, in both modes, and checks that the outputs hold. It then checks that the next bit still needs a falling tick and then a rising tick. A second hard case is a reset that arrives mid-word, between clock edges. The bench raises `sync_rst` half a period away from any edge, checks that the outputs clear before the next edge, and then repeats the start-up handshake in the other mode.

// File: rtl/par2ser_pkg.sv
package par2ser_pkg;

    // Start-up sequencer: waiting for a falling phase, armed, running
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    // Which half of an input clock period the current tick represents
    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_e;

endpackage

// File: rtl/par2ser_seq.sv
module par2ser_seq
    import par2ser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    input  logic rate_full,
    output logic step,
    output logic running
);

    typedef struct packed {
        seq_state_e st;
        phase_e     ph;
    } seq_regs_t;

    seq_regs_t seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        step  = 1'b0;
        if (clk_en) begin
            seq_d.ph = (seq_q.ph == PH_RISE) ? PH_FALL : PH_RISE;
            unique case (seq_q.st)
                SEQ_IDLE: begin
                    // the first falling phase after release arms the converter
                    if (seq_q.ph == PH_FALL) seq_d.st = SEQ_ARMED;
                end
                SEQ_ARMED: begin
                    // always a rising phase: present the first word
                    seq_d.st = SEQ_RUN;
                    step     = 1'b1;
                end
                SEQ_RUN: begin
                    step = rate_full ? (seq_q.ph == PH_RISE) : 1'b1;
                end
                default: seq_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) seq_q <= '{st: SEQ_IDLE, ph: PH_RISE};
        else     seq_q <= seq_d;
    end

    assign running = (seq_q.st == SEQ_RUN);

endmodule

// File: rtl/par2ser_shift.sv
module par2ser_shift #(
    parameter int WORD_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [WORD_W-1:0] par_in,
    output logic              ser_out,
    output logic              word_clk,
    output logic [IDX_W-1:0]  bit_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(WORD_W / 2);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic [IDX_W-1:0]  idx;
        logic              sout;
        logic              wclk;
    } shift_regs_t;

    shift_regs_t sh_q, sh_d;

    always_comb begin
        sh_d = sh_q;
        if (step) begin
            if (sh_q.idx == LAST_IDX) begin
                // word boundary: take a fresh word and present its bit 0
                sh_d.hold = par_in;
                sh_d.idx  = '0;
                sh_d.sout = par_in[0];
            end else begin
                sh_d.idx  = sh_q.idx + 1'b1;
                sh_d.sout = sh_q.hold[sh_d.idx];
            end
            sh_d.wclk = (sh_d.idx < HALF_IDX);
        end
    end

    // index resets to the last slot so that the first step loads a word
    always_ff @(posedge clk or posedge rst) begin
        if (rst) sh_q <= '{hold: '0, idx: LAST_IDX, sout: 1'b0, wclk: 1'b0};
        else     sh_q <= sh_d;
    end

    assign ser_out  = sh_q.sout;
    assign word_clk = sh_q.wclk;
    assign bit_idx  = sh_q.idx;

endmodule

// File: rtl/par2ser_top.sv
module par2ser_top #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              sync_rst,
    input  logic              clk_en,
    input  logic              rate_full,
    input  logic [WORD_W-1:0] par_in,
    output logic              ser_out,
    output logic              word_clk
);

    localparam int IDX_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;

    logic             step_w;
    logic             run_w;
    logic [IDX_W-1:0] idx_w;

    par2ser_seq u_seq (
        .clk       (clk),
        .rst       (sync_rst),
        .clk_en    (clk_en),
        .rate_full (rate_full),
        .step      (step_w),
        .running   (run_w)
    );

    par2ser_shift #(
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_shift (
        .clk      (clk),
        .rst      (sync_rst),
        .step     (step_w),
        .par_in   (par_in),
        .ser_out  (ser_out),
        .word_clk (word_clk),
        .bit_idx  (idx_w)
    );

endmodule

// File: rtl/par2ser_chk.sv
module par2ser_chk #(
    parameter int WORD_W = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en,
    input logic              rate_full,
    input logic [WORD_W-1:0] par_in,
    input logic              ser_out,
    input logic              word_clk,
    input logic              step,
    input logic              running,
    input logic [IDX_W-1:0]  bit_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    always @(posedge clk) begin
        if (rst) begin
            assert_reset_quiet_R5: assert (ser_out == 1'b0 && word_clk == 1'b0);
        end
    end

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !running |-> (ser_out == 1'b0 && word_clk == 1'b0));

    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(ser_out) && $stable(word_clk)));

    assert_full_rate_pace_R3: assert property (@(posedge clk) disable iff (rst)
        (rate_full && $past(rate_full) && (ser_out != $past(ser_out)))
        |=> ($stable(ser_out) && $stable(word_clk)));

    assert_word_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        (step && bit_idx == LAST_IDX) |=> word_clk);

    assert_capture_bit0_R8: assert property (@(posedge clk) disable iff (rst)
        (step && bit_idx == LAST_IDX) |=> (ser_out == $past(par_in[0])));

endmodule

bind par2ser_top par2ser_chk #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (sync_rst),
    .clk_en    (clk_en),
    .rate_full (rate_full),
    .par_in    (par_in),
    .ser_out   (ser_out),
    .word_clk  (word_clk),
    .step      (step_w),
    .running   (run_w),
    .bit_idx   (idx_w)
);

// File: tb/tb_par2ser_top.sv
module tb_par2ser_top;

    localparam int W = 8;

    logic         clk       = 1'b0;
    logic         sync_rst  = 1'b1;
    logic         clk_en    = 1'b1;
    logic         rate_full = 1'b1;
    logic [W-1:0] par_in    = '0;
    logic         ser_out;
    logic         word_clk;

    int checks   = 0;
    int failures = 0;

    par2ser_top #(.WORD_W(W)) dut (
        .clk       (clk),
        .sync_rst  (sync_rst),
        .clk_en    (clk_en),
        .rate_full (rate_full),
        .par_in    (par_in),
        .ser_out   (ser_out),
        .word_clk  (word_clk)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one tick, then sample and drive at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // reset, choose mode, release and walk through the start handshake
    task automatic start_run(input logic full, input logic [W-1:0] first);
        sync_rst  = 1'b1;
        rate_full = full;
        clk_en    = 1'b1;
        par_in    = first;
        tick();
        check("R5", "ser_out in reset", 32'(ser_out), 32'd0);
        check("R5", "word_clk in reset", 32'(word_clk), 32'd0);
        sync_rst = 1'b0;
        tick();
        check("R6", "word_clk after tick 1", 32'(word_clk), 32'd0);
        check("R6", "ser_out after tick 1", 32'(ser_out), 32'd0);
        tick();
        check("R6", "word_clk after tick 2", 32'(word_clk), 32'd0);
        tick();
        check("R6", "word_clk after tick 3", 32'(word_clk), 32'd1);
        check("R6", "bit 0 after tick 3", 32'(ser_out), 32'(first[0]));
    endtask

    // hold clk_en low for some ticks and confirm nothing moves
    task automatic stall(input int n);
        logic s0;
        logic w0;
        s0 = ser_out;
        w0 = word_clk;
        clk_en = 1'b0;
        for (int k = 0; k < n; k++) begin
            tick();
            check("R7", "ser_out frozen", 32'(ser_out), 32'(s0));
            check("R7", "word_clk frozen", 32'(word_clk), 32'(w0));
        end
        clk_en = 1'b1;
    endtask

    // stream n words starting just after bit 0 of 'first' was presented
    task automatic run_words(input logic full, input logic [W-1:0] first,
                             input int n, input int stall_bit);
        logic [W-1:0] cur;
        logic [W-1:0] nxt;
        logic [W-1:0] got;
        string        rq;
        cur = first;
        rq  = full ? "R3" : "R4";
        for (int w = 0; w < n; w++) begin
            nxt = W'($urandom);
            got = '0;
            for (int i = 0; i < W; i++) begin
                if (!(w == 0 && i == 0)) begin
                    if (w == 0 && i == stall_bit) stall(5);
                    if (full) begin
                        logic s_prev;
                        logic w_prev;
                        s_prev = ser_out;
                        w_prev = word_clk;
                        tick();
                        check("R3", "hold on falling phase", 32'(ser_out), 32'(s_prev));
                        check("R3", "word_clk hold on falling phase", 32'(word_clk), 32'(w_prev));
                    end
                    tick();
                end
                check(rq, $sformatf("bit %0d timing", i), 32'(ser_out), 32'(cur[i]));
                check("R2", $sformatf("word_clk at bit %0d", i), 32'(word_clk),
                      (i < W / 2) ? 32'd1 : 32'd0);
                got[i] = ser_out;
                // garbage mid-word, the next word only before the boundary
                par_in = (i == W - 1) ? nxt : W'($urandom);
            end
            check("R1 R8", "reassembled word", 32'(got), 32'(cur));
            cur = nxt;
        end
    endtask

    task automatic test_full_rate();
        logic [W-1:0] f;
        f = 8'hA5;
        start_run(1'b1, f);
        run_words(1'b1, f, 3, W);
    endtask

    task automatic test_double_rate();
        logic [W-1:0] f;
        f = 8'h3C;
        start_run(1'b0, f);
        run_words(1'b0, f, 3, W);
    endtask

    task automatic test_enable_full();
        logic [W-1:0] f;
        f = 8'h96;
        start_run(1'b1, f);
        run_words(1'b1, f, 2, 3);
    endtask

    task automatic test_enable_double();
        logic [W-1:0] f;
        f = 8'h71;
        start_run(1'b0, f);
        run_words(1'b0, f, 2, 5);
    endtask

    task automatic test_midword_reset();
        logic [W-1:0] f;
        f = 8'hFF;
        start_run(1'b0, f);
        par_in = 8'h00;
        tick();
        tick();
        #2 sync_rst = 1'b1;
        #1;
        check("R5", "ser_out cleared without edge", 32'(ser_out), 32'd0);
        check("R5", "word_clk cleared without edge", 32'(word_clk), 32'd0);
        @(negedge clk);
        f = 8'h5A;
        start_run(1'b1, f);
        run_words(1'b1, f, 2, W);
    endtask

    initial begin
        tick();
        check("R5", "ser_out at power-up reset", 32'(ser_out), 32'd0);
        check("R5", "word_clk at power-up reset", 32'(word_clk), 32'd0);
        test_full_rate();
        test_double_rate();
        test_enable_full();
        test_enable_double();
        test_midword_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule